// File: doc/BRIEF.md
# Virtual-Channel Router Input Port with Downstream Credit Tracking

This block is one input port of a wormhole router that multiplexes several virtual channels over a single link. Each arriving flit names its virtual channel in a small identifier field at its top. The port uses that identifier to choose one of several per-channel FIFOs, and it stores the flit with the identifier removed. Flits whose valid flag is clear are void and never reach storage.

A switch stage outside this block makes the allocation decisions. It picks a local FIFO to drain and the virtual channel the flit will occupy in the next router. The port then puts that new identifier in front of the stored flit and drives the result on a registered output. It does this only when the chosen FIFO holds a flit and the target downstream channel has at least one credit. One credit counter exists for each downstream channel. A counter starts at the downstream FIFO depth, drops by one for every flit sent into that channel and rises by one for every credit returned. The port shows its state to the allocators through the per-channel head flits, the empty and full flags and the credit-available flags.

Top module: `vcip_input_port`

## Requirements
- R1: After reset every FIFO is empty and not full, every credit-available flag is 1, `out_flit` is all zeros and `ovf_err` is 0.
- R2: The flit layout from the MSB down is a channel identifier of log2(NUM_VC) bits, one valid bit (1 = valid), a 2-bit type (01 head, 11 body, 10 tail) and the payload. A valid flit whose identifier is k is written only into FIFO k. The stored slot is the flit without its identifier, and it appears on slot k of `head_flits` when that FIFO is the oldest entry.
- R3: A flit whose valid bit is 0 writes no FIFO, whatever its identifier.
- R4: Each FIFO returns its flits in arrival order and holds FIFO_DEPTH entries. `vc_full` is 1 exactly when FIFO_DEPTH flits are held, and `vc_empty` is 1 exactly when none are held.
- R5: A write to a full FIFO that is not popped in the same cycle is dropped. `ovf_err` is then 1 for the single following cycle.
- R6: An accepted send takes place when `send_en` is 1, FIFO `send_src` is not empty and `credit_ok[send_dst]` is 1. It pops that FIFO, and in the next cycle `out_flit` equals `send_dst` concatenated above the popped slot.
- R7: A send that is not accepted pops nothing, leaves every credit count unchanged and makes `out_flit` all zeros, a void flit, in the next cycle.
- R8: Each downstream channel count drops by one for every accepted send to it and rises by one for every `credit_ret` pulse. Its `credit_ok` is 0 exactly when the count is zero, which happens after DS_DEPTH sends with no returns.
- R9: A write and an accepted pop on the same FIFO in one cycle both take effect, even when the FIFO is full, and no overflow is flagged.
- R10: An accepted send to a channel together with a credit return to that channel in the same cycle leaves that channel's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flit | input | FLIT_W | Flit arriving from the upstream link |
| send_en | input | 1 | Request to send one flit downstream this cycle |
| send_src | input | log2(NUM_VC) | Local FIFO to drain |
| send_dst | input | log2(NUM_VC) | Downstream channel identifier to prepend |
| credit_ret | input | NUM_VC | One credit returned per downstream channel |
| out_flit | output | FLIT_W | Registered outgoing flit, all zeros when idle |
| head_flits | output | NUM_VC*(FLIT_W-log2(NUM_VC)) | Oldest stored slot of each FIFO |
| vc_empty | output | NUM_VC | FIFO holds no flit |
| vc_full | output | NUM_VC | FIFO holds FIFO_DEPTH flits |
| credit_ok | output | NUM_VC | Downstream channel count is nonzero |
| ovf_err | output | 1 | A write to a full FIFO was dropped in the previous cycle |

## Verification
The bench goes after five corner cases.

- Void flits addressed to every channel: a port that ignored the valid bit would clear an empty flag.
- Writes into full FIFOs, with and without a same-cycle pop: a wrong design would either overwrite the oldest entry or refuse a legal write during a pop.
- Running a downstream channel to zero credits: an off-by-one counter would allow a fifth send or block the fourth.
- A send and a credit return to the same channel in one cycle: a counter that only honoured one of them would drift.
- Several thousand cycles of mixed traffic against an arithmetic queue-and-counter model: this exposes a wrong identifier splice or a pop of the wrong FIFO through `out_flit` and `head_flits`.

// File: rtl/vcip_pkg.sv
// Shared definitions for the virtual-channel input port.
// Assumes the flit layout: channel id at the MSBs, then valid bit, then type.
package vcip_pkg;
    typedef enum logic [1:0] {
        FK_RSVD = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_BODY = 2'b11
    } flit_kind_e;
endpackage

// File: rtl/vcip_fifo.sv
// Per-channel flit FIFO: one write and one read per cycle, any depth >= 1.
// Assumes rd_en is only raised while the FIFO is non-empty (checked below).
// A write while full and not read is dropped and flagged on ovf next cycle.
module vcip_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             accept;

    // Write is taken when space exists or the same cycle frees a slot.
    assign accept  = wr_en && (!full || rd_en);
    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign rd_data = mem[rptr];

    // Storage array; no reset needed for data.
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_data;
    end

    // Pointer, occupancy and overflow flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_en)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (accept && !rd_en)      count <= count + 1'b1;
            else if (!accept && rd_en) count <= count - 1'b1;
            ovf <= wr_en && full && !rd_en;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_full_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> full);
    assert_full_pop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && rd_en) |=> (full && !ovf));
endmodule

// File: rtl/vcip_credit.sv
// Credit counter for one downstream virtual channel.
// Starts at MAX free slots; dec for a sent flit, inc for a returned credit.
// Assumes the neighbour never returns more credits than it was sent flits.
module vcip_credit #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dec,
    input  logic inc,
    output logic avail
);
    localparam int CW = $clog2(MAX + 1);
    localparam logic [CW-1:0] INIT = CW'(MAX);

    logic [CW-1:0] cnt;

    assign avail = (cnt != '0);

    // Net count update; simultaneous dec and inc cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= INIT;
        else if (dec && !inc) cnt <= cnt - 1'b1;
        else if (inc && !dec) cnt <= cnt + 1'b1;
    end

    assert_credit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= INIT);
    assert_no_send_without_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt != '0);
    assert_balanced_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && inc) |=> $stable(cnt));
endmodule

// File: rtl/vcip_input_port.sv
// Router input port: steers valid flits by their channel id into per-channel
// FIFOs (id stripped), and sends one flit per cycle downstream with a new id
// prepended when the source FIFO is non-empty and the target channel has credit.
// Assumes NUM_VC is a power of two, at least 2.
module vcip_input_port
    import vcip_pkg::*;
#(
    parameter int NUM_VC     = 4,
    parameter int FLIT_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int DS_DEPTH   = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [FLIT_W-1:0]                            in_flit,
    input  logic                                         send_en,
    input  logic [$clog2(NUM_VC)-1:0]                    send_src,
    input  logic [$clog2(NUM_VC)-1:0]                    send_dst,
    input  logic [NUM_VC-1:0]                            credit_ret,
    output logic [FLIT_W-1:0]                            out_flit,
    output logic [NUM_VC*(FLIT_W-$clog2(NUM_VC))-1:0]    head_flits,
    output logic [NUM_VC-1:0]                            vc_empty,
    output logic [NUM_VC-1:0]                            vc_full,
    output logic [NUM_VC-1:0]                            credit_ok,
    output logic                                         ovf_err
);
    localparam int VC_W   = $clog2(NUM_VC);
    localparam int SLOT_W = FLIT_W - VC_W;
    localparam int VLD_B  = SLOT_W - 1;

    logic [VC_W-1:0]   in_id;
    logic              in_valid;
    logic [SLOT_W-1:0] in_slot;
    logic              fire;
    logic [NUM_VC-1:0] fifo_ovf;
    logic [SLOT_W-1:0] src_head;

    assign in_id    = in_flit[FLIT_W-1 -: VC_W];
    assign in_valid = in_flit[VLD_B];
    assign in_slot  = in_flit[SLOT_W-1:0];
    assign fire     = send_en && !vc_empty[send_src] && credit_ok[send_dst];
    assign src_head = head_flits[send_src*SLOT_W +: SLOT_W];
    assign ovf_err  = |fifo_ovf;

    for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
        logic wr_i, rd_i, dec_i;
        // Per-channel steering of writes, pops and credit debits.
        assign wr_i  = in_valid && (in_id == VC_W'(i));
        assign rd_i  = fire && (send_src == VC_W'(i));
        assign dec_i = fire && (send_dst == VC_W'(i));

        vcip_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_i),
            .wr_data (in_slot),
            .rd_en   (rd_i),
            .rd_data (head_flits[i*SLOT_W +: SLOT_W]),
            .empty   (vc_empty[i]),
            .full    (vc_full[i]),
            .ovf     (fifo_ovf[i])
        );

        vcip_credit #(.MAX(DS_DEPTH)) u_cred (
            .clk   (clk),
            .rst_n (rst_n),
            .dec   (dec_i),
            .inc   (credit_ret[i]),
            .avail (credit_ok[i])
        );
    end

    // Output register: relabelled flit on an accepted send, void otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_flit <= '0;
        else if (fire) out_flit <= {send_dst, src_head};
        else           out_flit <= '0;
    end

    assert_void_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !send_en |=> out_flit[VLD_B] == 1'b0);
    assert_void_in_no_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !send_en && vc_empty[in_id]) |=> vc_empty[$past(in_id)]);
    assert_send_keeps_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_flit[SLOT_W-1:0] == $past(src_head));
endmodule

// File: tb/tb_vcip_input_port.sv
module tb_vcip_input_port;
    import vcip_pkg::*;
    localparam int NV = 4, FW = 16, FD = 4, DS = 4;
    localparam int VW = $clog2(NV), SW = FW - VW, PW = SW - 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [FW-1:0] in_flit = '0;
    logic send_en = 1'b0;
    logic [VW-1:0] send_src = '0, send_dst = '0;
    logic [NV-1:0] credit_ret = '0;
    logic [FW-1:0] out_flit;
    logic [NV*SW-1:0] head_flits;
    logic [NV-1:0] vc_empty, vc_full, credit_ok;
    logic ovf_err;

    int n_tests = 0, n_fail = 0;
    logic [SW-1:0] mq [NV][$];
    int cred [NV];
    bit done = 0;

    vcip_input_port #(.NUM_VC(NV), .FLIT_W(FW), .FIFO_DEPTH(FD), .DS_DEPTH(DS)) dut (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .send_en(send_en),
        .send_src(send_src), .send_dst(send_dst), .credit_ret(credit_ret),
        .out_flit(out_flit), .head_flits(head_flits), .vc_empty(vc_empty),
        .vc_full(vc_full), .credit_ok(credit_ok), .ovf_err(ovf_err));

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input int vc, input logic v, input flit_kind_e t, input int p);
        return {vc[VW-1:0], v, t, p[PW-1:0]};
    endfunction

    // One cycle: drive at negedge, update model, check 1 ns after the edge.
    task automatic step(input logic [FW-1:0] f, input logic se, input int s, input int d,
                        input logic [NV-1:0] ret);
        logic fire, exp_ovf;
        logic [FW-1:0] exp_out;
        int k;
        @(negedge clk);
        in_flit = f; send_en = se; send_src = s[VW-1:0]; send_dst = d[VW-1:0]; credit_ret = ret;
        fire = se && (mq[s].size() > 0) && (cred[d] > 0);
        exp_out = fire ? {d[VW-1:0], mq[s][0]} : '0;
        if (fire) begin
            void'(mq[s].pop_front());
            cred[d]--;
        end
        exp_ovf = 1'b0;
        if (f[SW-1]) begin
            k = int'(f[FW-1 -: VW]);
            if (mq[k].size() < FD) mq[k].push_back(f[SW-1:0]);
            else exp_ovf = 1'b1;
        end
        for (int i = 0; i < NV; i++) if (ret[i]) cred[i]++;
        @(posedge clk);
        #1;
        chk(fire ? "R6 out_flit" : "R7 out_flit", 32'(out_flit), 32'(exp_out));
        chk("R5 ovf_err", 32'(ovf_err), 32'(exp_ovf));
        for (int i = 0; i < NV; i++) begin
            chk("R4 empty", 32'(vc_empty[i]), 32'(mq[i].size() == 0));
            chk("R4 full", 32'(vc_full[i]), 32'(mq[i].size() == FD));
            chk("R8 credit_ok", 32'(credit_ok[i]), 32'(cred[i] > 0));
            if (mq[i].size() > 0)
                chk("R2 head", 32'(head_flits[i*SW +: SW]), 32'(mq[i][0]));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NV-1:0] r;
        flit_kind_e kinds [3] = '{FK_HEAD, FK_BODY, FK_TAIL};
        for (int i = 0; i < NV; i++) cred[i] = DS;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty", 32'(vc_empty), 32'({NV{1'b1}}));
        chk("R1 full", 32'(vc_full), 32'(0));
        chk("R1 credit_ok", 32'(credit_ok), 32'({NV{1'b1}}));
        chk("R1 out_flit", 32'(out_flit), 32'(0));
        chk("R1 ovf_err", 32'(ovf_err), 32'(0));

        // R3: void flits to every channel leave all FIFOs empty.
        for (int v = 0; v < NV; v++) step(mk(v, 1'b0, FK_HEAD, 100 + v), 1'b0, 0, 0, '0);
        chk("R3 void no write", 32'(vc_empty), 32'({NV{1'b1}}));

        // R2/R4: fill every channel with all flit kinds.
        for (int v = 0; v < NV; v++)
            for (int n = 0; n < FD; n++)
                step(mk(v, 1'b1, kinds[n % 3], v * 16 + n), 1'b0, 0, 0, '0);
        // R5: overflow on each full channel.
        for (int v = 0; v < NV; v++) step(mk(v, 1'b1, FK_BODY, 300 + v), 1'b0, 0, 0, '0);

        // R9: write and pop together on full channel 0.
        step(mk(0, 1'b1, FK_TAIL, 400), 1'b1, 0, 0, '0);
        chk("R9 still full", 32'(vc_full[0]), 32'(1));
        chk("R9 no overflow", 32'(ovf_err), 32'(0));

        // R8: drain channel 1 into downstream 2 until credits run out.
        for (int n = 0; n < DS; n++) begin
            chk("R8 credit before", 32'(credit_ok[2]), 32'(1));
            step('0, 1'b1, 1, 2, '0);
        end
        chk("R8 credit exhausted", 32'(credit_ok[2]), 32'(0));
        step('0, 1'b1, 3, 2, '0);
        chk("R7 refused void", 32'(out_flit), 32'(0));
        chk("R7 source kept", 32'(vc_full[3]), 32'(1));

        // R10: send and return on the same channel keep the count at one.
        step('0, 1'b0, 0, 0, 4'b0100);
        step('0, 1'b1, 3, 2, 4'b0100);
        chk("R10 balanced", 32'(credit_ok[2]), 32'(1));
        step('0, 1'b1, 3, 2, '0);
        chk("R10 then empty", 32'(credit_ok[2]), 32'(0));

        // Mixed traffic sweep against the model.
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NV; i++) r[i] = (($urandom % 3) == 0) && (cred[i] < DS);
            step(mk($urandom % NV, ($urandom % 4) != 0, kinds[$urandom % 3], $urandom),
                 ($urandom % 3) != 0, $urandom % NV, $urandom % NV, r);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule